// File: doc/BRIEF.md
# Packed Element Interleaver

This block takes two 128-bit packed operands and builds a result by alternating their elements. The elements come from either the lower or the upper half of both operands. An element can be 8, 16, 32 or 64 bits wide. In every result pair the element from the first operand sits in the lower slot and the element from the second operand sits in the slot above it.

The result is meant to overwrite the first operand in the register file. Operand fetch and writeback are handled elsewhere. The unit accepts one operation per clock when its valid strobe is high. It returns the registered result, with a matching valid flag, one clock later. While no operation is accepted, the result register keeps its last value.

Top module: `simd_interleave_unit`

## Requirements
- R1: A synchronous active-high reset clears the result to zero and the output valid flag to 0.
- R2: The output valid flag is high in exactly the cycle after a cycle in which the input valid strobe was high, and is low otherwise.
- R3: With mode 3'b000 (bits 1:0 = 00 byte elements, bit 2 = 0 low half), result byte 2k equals first-operand byte k and result byte 2k+1 equals second-operand byte k, for k = 0..7.
- R4: With mode 3'b100 (byte elements, high half), result byte 2k equals first-operand byte 8+k and result byte 2k+1 equals second-operand byte 8+k, for k = 0..7.
- R5: With bits 1:0 = 01 (16-bit elements), result word 2k equals first-operand word h+k and result word 2k+1 equals second-operand word h+k, for k = 0..3. Here h = 0 when bit 2 is 0 and h = 4 when bit 2 is 1.
- R6: With bits 1:0 = 10 (32-bit elements), result doubleword 2k equals first-operand doubleword h+k and result doubleword 2k+1 equals second-operand doubleword h+k, for k = 0..1. Here h = 0 for the low half and h = 2 for the high half.
- R7: With mode 3'b011 (64-bit elements, low half), result bits 63:0 equal first-operand bits 63:0 and result bits 127:64 equal second-operand bits 63:0.
- R8: With mode 3'b111 (64-bit elements, high half), result bits 63:0 equal first-operand bits 127:64 and result bits 127:64 equal second-operand bits 127:64.
- R9: In a cycle with the input valid strobe low, changes on the operands and the mode have no effect: the result is unchanged at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept the operands and mode this cycle |
| mode | input | 3 | Bits 1:0 element size (00 byte, 01 word, 10 dword, 11 qword); bit 2 half select (0 low, 1 high) |
| opa | input | 128 | First operand; supplies the even result slots |
| opb | input | 128 | Second operand; supplies the odd result slots |
| out_valid | output | 1 | Result register holds a new value |
| result | output | 128 | Registered interleaved result |

## Verification
Each of the eight modes is run with three kinds of operands.

- Byte-index operands give every byte a distinct value, with the second operand's bytes marked by their top bit. Any misplaced slot, wrong half or swapped operand therefore shows up as a specific wrong byte.
- Random operands catch errors in the bit ordering within an element.
- All-ones against all-zeros operands make the even/odd slot pattern of each element size plainly visible.

Back-to-back operations with a different mode each cycle separate a correct per-cycle capture from a stale mode. Idle cycles with changing operands show that the result holds while the strobe is low.

// File: rtl/simd_interleave_pkg.sv
package simd_interleave_pkg;
    localparam int NUM_SIZES = 4;

    typedef enum logic [1:0] {
        ESZ_BYTE  = 2'b00,
        ESZ_WORD  = 2'b01,
        ESZ_DWORD = 2'b10,
        ESZ_QWORD = 2'b11
    } elem_size_e;

    // element width in bits for a size code
    function automatic int elem_bits(int code);
        return 8 << code;
    endfunction
endpackage

// File: rtl/ilv_lane.sv
// Interleaves one element size for both halves and picks the half.
module ilv_lane #(
    parameter int DATA_W = 128,
    parameter int ELEM_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              hi,
    output logic [DATA_W-1:0] y
);
    localparam int NUM_ELEM = DATA_W / ELEM_W;
    localparam int HALF     = NUM_ELEM / 2;

    logic [DATA_W-1:0] y_lo;
    logic [DATA_W-1:0] y_hi;

    for (genvar k = 0; k < HALF; k++) begin : g_pair
        assign y_lo[(2*k)*ELEM_W   +: ELEM_W] = a[k*ELEM_W +: ELEM_W];
        assign y_lo[(2*k+1)*ELEM_W +: ELEM_W] = b[k*ELEM_W +: ELEM_W];
        assign y_hi[(2*k)*ELEM_W   +: ELEM_W] = a[(HALF+k)*ELEM_W +: ELEM_W];
        assign y_hi[(2*k+1)*ELEM_W +: ELEM_W] = b[(HALF+k)*ELEM_W +: ELEM_W];
    end

    assign y = hi ? y_hi : y_lo;
endmodule

// File: rtl/simd_interleave_unit.sv
module simd_interleave_unit
    import simd_interleave_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        mode,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
    } state_t;

    state_t state_d;
    state_t state_q;

    logic [DATA_W-1:0] lane_y [NUM_SIZES];
    elem_size_e        size_sel;

    assign size_sel = elem_size_e'(mode[1:0]);

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        ilv_lane #(
            .DATA_W (DATA_W),
            .ELEM_W (elem_bits(s))
        ) lane_i (
            .a  (opa),
            .b  (opb),
            .hi (mode[2]),
            .y  (lane_y[s])
        );
    end

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.res = lane_y[size_sel];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign result    = state_q.res;
endmodule

// File: rtl/simd_interleave_unit_chk.sv
module simd_interleave_unit_chk #(
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [2:0]        mode,
    input logic [DATA_W-1:0] opa,
    input logic [DATA_W-1:0] opb,
    input logic              out_valid,
    input logic [DATA_W-1:0] result
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0)); // R1

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2

    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2

    AST_BYTE_LOW: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 3'b000) |=>
        (result[7:0] == $past(opa[7:0]) && result[15:8] == $past(opb[7:0]))); // R3

    AST_BYTE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 3'b100) |=>
        (result[7:0] == $past(opa[71:64]) && result[127:120] == $past(opb[127:120]))); // R4

    AST_QWORD_LOW: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 3'b011) |=>
        (result[63:0] == $past(opa[63:0]) && result[127:64] == $past(opb[63:0]))); // R7

    AST_QWORD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 3'b111) |=>
        (result[63:0] == $past(opa[127:64]) && result[127:64] == $past(opb[127:64]))); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result)); // R9
endmodule

bind simd_interleave_unit simd_interleave_unit_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/simd_interleave_unit_tb_top.sv
module simd_interleave_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 128;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [2:0]   mode = 3'b000;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic         out_valid;
    logic [W-1:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_interleave_unit #(.DATA_W(W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .mode      (mode),
        .opa       (opa),
        .opb       (opb),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [W-1:0] model(logic [2:0] m, logic [W-1:0] a, logic [W-1:0] b);
        logic [W-1:0] r = '0;
        int ew   = 8 << m[1:0];
        int n    = W / ew;
        int base = m[2] ? n / 2 : 0;
        for (int k = 0; k < n / 2; k++) begin
            for (int j = 0; j < ew; j++) begin
                r[(2*k)*ew + j]   = a[(base+k)*ew + j];
                r[(2*k+1)*ew + j] = b[(base+k)*ew + j];
            end
        end
        return r;
    endfunction

    function automatic string req_of(logic [2:0] m);
        case (m)
            3'b000:         return "R3";
            3'b100:         return "R4";
            3'b001, 3'b101: return "R5";
            3'b010, 3'b110: return "R6";
            3'b011:         return "R7";
            default:        return "R8";
        endcase
    endfunction

    task automatic check_vec(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_bit(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // single accepted operation, checked one clock later
    task automatic run_op(logic [2:0] m, logic [W-1:0] a, logic [W-1:0] b);
        @(negedge clk);
        in_valid = 1'b1; mode = m; opa = a; opb = b;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit("R2", out_valid, 1'b1);
        check_vec(req_of(m), result, model(m, a, b));
    endtask

    logic [W-1:0] idx_a, idx_b, rnd_a, rnd_b, last;

    initial begin
        for (int i = 0; i < 16; i++) begin
            idx_a[i*8 +: 8] = 8'(i);
            idx_b[i*8 +: 8] = 8'(8'h80 | i);
        end

        repeat (3) @(negedge clk);
        check_bit("R1", out_valid, 1'b0);           // R1
        check_vec("R1", result, '0);
        rst = 1'b0;

        for (int m = 0; m < 8; m++) begin
            run_op(3'(m), idx_a, idx_b);
            run_op(3'(m), {W{1'b1}}, '0);
            for (int r = 0; r < 4; r++) begin
                rnd_a = {$urandom, $urandom, $urandom, $urandom};
                rnd_b = {$urandom, $urandom, $urandom, $urandom};
                run_op(3'(m), rnd_a, rnd_b);
            end
        end

        // back-to-back stream with changing mode (R2, R3..R8)
        @(negedge clk);
        for (int m = 7; m >= 0; m--) begin
            rnd_a = {$urandom, $urandom, $urandom, $urandom};
            rnd_b = {$urandom, $urandom, $urandom, $urandom};
            in_valid = 1'b1; mode = 3'(m); opa = rnd_a; opb = rnd_b;
            @(negedge clk);
            check_bit("R2", out_valid, 1'b1);
            check_vec(req_of(3'(m)), result, model(3'(m), rnd_a, rnd_b));
        end
        in_valid = 1'b0;

        // idle cycles: operand and mode changes ignored (R9), valid low (R2)
        last = result;
        for (int i = 0; i < 4; i++) begin
            mode = 3'(i * 3);
            opa  = {$urandom, $urandom, $urandom, $urandom};
            opb  = ~opa;
            @(negedge clk);
            check_bit("R2", out_valid, 1'b0);
            check_vec("R9", result, last);
        end

        // reset after activity clears state (R1)
        run_op(3'b101, idx_a, idx_b);
        rst = 1'b1;
        @(negedge clk);
        check_bit("R1", out_valid, 1'b0);
        check_vec("R1", result, '0);
        rst = 1'b0;

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule